// File: doc/BRIEF.md
# String Store Execution Unit

This unit carries out one store-string operation. A caller presents the accumulator, an operand-size code, an address-size code, the direction flag, the destination index register, the destination segment base and the processor mode. It then pulses `start`. The unit checks that the encoding is legal in the current mode. It forms the destination address from the index register and the fixed destination segment, and writes the low bytes of the accumulator to memory through a valid/ready port with byte enables on a 64-bit bus. When every write beat has been accepted, it presents the stepped index register.

The destination segment is fixed and has no override path, because only one segment base enters the unit. The index register steps by the operand size, and the direction flag selects whether it goes up or down. The step wraps at the address-size width. A store that crosses an 8-byte bus boundary goes out as two writes, and the lower address is always written first. An illegal encoding produces a one-cycle `invalid` pulse and no memory write.

The control is a five-state machine:
- IDLE waits for `start`.
- IDLE goes to REJECT on an illegal encoding, and to BEAT_LO on a legal one.
- REJECT raises `invalid` for one cycle and goes back to IDLE.
- BEAT_LO holds the lower write beat until `wr_ready` is high.
- From BEAT_LO, the machine goes to BEAT_HI when the store crosses a bus boundary, and to FINISH when it does not.
- BEAT_HI holds the upper beat until `wr_ready` is high, then goes to FINISH.
- FINISH raises `done` for one cycle, with the new index value already on `idx_out`, and goes back to IDLE.

Top module: `strstore_unit`

## Requirements
- R1: The operand-size code `op_size` is 0 for byte, 1 for word, 2 for doubleword and 3 for quadword. The data written is the low 1, 2, 4 or 8 bytes of `acc`, placed in the byte lanes given by the low 3 bits of the linear address.
- R2: The address-size code `addr_size` is 0 for 16-bit, 1 for 32-bit and 2 for 64-bit. The address offset is `idx_in` bits 15:0, bits 31:0 or bits 63:0 respectively, zero-extended to 64 bits.
- R3: `cpu_mode` value 2 means 64-bit mode. In 64-bit mode the linear address is the offset itself. Any other `cpu_mode` value means legacy or compatibility mode, where the linear address is `es_base` plus the offset.
- R4: The index register changes by 1, 2, 4 or 8 for byte, word, doubleword and quadword operations.
- R5: With `dir_flag` at 0 the index register is incremented. With `dir_flag` at 1 it is decremented.
- R6: The following encodings are illegal:
  - a quadword operation outside 64-bit mode;
  - a 64-bit address size outside 64-bit mode;
  - a 16-bit address size in 64-bit mode;
  - `addr_size` 3.

  An illegal encoding raises `invalid` in the cycle after `start`, issues no write, and leaves `idx_out` unchanged.
- R7: `wr_addr` is the linear address with bits 2:0 cleared. `wr_be` bit i enables byte lane i. Across all beats of an operation, exactly the operand's bytes are enabled.
- R8: An access that crosses an 8-byte boundary is issued as two beats. The first beat goes to the lower aligned address, and the second goes to that address plus 8 and carries lanes from 0 upward.
- R9: Wraparound follows the address size:
  - With a 16-bit address size only bits 15:0 change.
  - With a 32-bit address size outside 64-bit mode, bits 63:32 are kept.
  - With a 32-bit address size in 64-bit mode, the result is zero-extended.
  - With a 64-bit address size the full register wraps modulo 2^64.
- R10: While `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_be` and `wr_data` hold steady. `idx_out` changes only in the cycle in which `done` is high.
- R11: `busy` is high from the cycle after an accepted `start` through the `done` or `invalid` cycle. A `start` seen while busy is ignored.
- R12: `done` is high for one cycle, in the cycle after the last beat is accepted. Inputs are captured at `start`, so changing them later has no effect on the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when not busy) |
| op_size | input | 2 | Operand size code |
| addr_size | input | 2 | Address size code |
| dir_flag | input | 1 | Direction flag (1 = decrement) |
| cpu_mode | input | 2 | Processor mode (2 = 64-bit) |
| acc | input | 64 | Accumulator value |
| idx_in | input | 64 | Destination index register |
| es_base | input | 64 | Destination segment base |
| busy | output | 1 | Operation in progress |
| invalid | output | 1 | Illegal-encoding pulse |
| done | output | 1 | Completion pulse |
| idx_out | output | 64 | Updated index register |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 64 | 8-byte-aligned write address |
| wr_be | output | 8 | Byte enables |
| wr_data | output | 64 | Write data in byte lanes |

## Verification
The bench builds the unit with its default widths: a 64-bit index register and a 64-bit data bus. This is the only setting that reaches every operand size up to quadword. It also lets an access straddle one lane boundary, so both the single-beat and the two-beat paths are exercised at every lane offset. A random `wr_ready` stretches each beat, which exercises the hold behaviour. The directed cases drive pointers to the 16-bit, 32-bit and 64-bit wrap points in both directions, with nonzero upper bits present.

// File: rtl/strstore_pkg.sv
package strstore_pkg;

    typedef enum logic [1:0] {
        OPS_BYTE  = 2'd0,
        OPS_WORD  = 2'd1,
        OPS_DWORD = 2'd2,
        OPS_QWORD = 2'd3
    } opsize_e;

    typedef enum logic [1:0] {
        AW_16  = 2'd0,
        AW_32  = 2'd1,
        AW_64  = 2'd2,
        AW_RSV = 2'd3
    } awidth_e;

    localparam logic [1:0] MODE_LONG = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_REJECT  = 3'd1,
        ST_BEAT_LO = 3'd2,
        ST_BEAT_HI = 3'd3,
        ST_FINISH  = 3'd4
    } st_e;

    typedef struct packed {
        logic [1:0] size;
        logic [1:0] aw;
        logic       df;
        logic       long_mode;
    } req_ctl_t;

endpackage

// File: rtl/strstore_addr.sv
module strstore_addr
    import strstore_pkg::*;
#(
    parameter int IDX_W = 64
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] seg_base,
    input  logic [1:0]       aw,
    input  logic             long_mode,
    output logic [IDX_W-1:0] lin
);
    logic [IDX_W-1:0] ofs;

    // Offset is the index truncated to the address size, zero-extended.
    always_comb begin
        unique case (awidth_e'(aw))
            AW_16:   ofs = {{(IDX_W-16){1'b0}}, idx[15:0]};
            AW_32:   ofs = {{(IDX_W-32){1'b0}}, idx[31:0]};
            default: ofs = idx;
        endcase
        // In 64-bit mode the segment base does not take part.
        lin = long_mode ? ofs : (seg_base + ofs);
    end
endmodule

// File: rtl/strstore_lanes.sv
module strstore_lanes #(
    parameter int IDX_W = 64,
    parameter int BUS_W = 64
) (
    input  logic [BUS_W-1:0]   acc,
    input  logic [1:0]         size,
    input  logic [IDX_W-1:0]   lin,
    output logic [IDX_W-1:0]   lo_addr,
    output logic [IDX_W-1:0]   hi_addr,
    output logic [BUS_W-1:0]   lo_data,
    output logic [BUS_W-1:0]   hi_data,
    output logic [BUS_W/8-1:0] lo_be,
    output logic [BUS_W/8-1:0] hi_be,
    output logic               split
);
    localparam int NB = BUS_W / 8;
    localparam int OB = $clog2(NB);

    logic [NB-1:0]    smask;
    logic [BUS_W-1:0] kept;
    logic [2*NB-1:0]  wide_be;
    logic [2*BUS_W-1:0] wide_data;
    logic [OB-1:0]    lane;

    // One byte-select per lane: lane i belongs to the operand when i < 2**size.
    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign smask[i] = (i < (1 << size));
        assign kept[8*i +: 8] = smask[i] ? acc[8*i +: 8] : 8'h00;
    end

    assign lane = lin[OB-1:0];

    always_comb begin
        wide_be   = {{NB{1'b0}}, smask} << lane;
        wide_data = {{BUS_W{1'b0}}, kept} << {lane, 3'b000};
        lo_addr   = {lin[IDX_W-1:OB], {OB{1'b0}}};
        hi_addr   = lo_addr + IDX_W'(NB);
        lo_be     = wide_be[NB-1:0];
        hi_be     = wide_be[2*NB-1:NB];
        lo_data   = wide_data[BUS_W-1:0];
        hi_data   = wide_data[2*BUS_W-1:BUS_W];
        split     = |hi_be;
    end
endmodule

// File: rtl/strstore_step.sv
module strstore_step
    import strstore_pkg::*;
#(
    parameter int IDX_W = 64
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       size,
    input  logic             df,
    input  logic [1:0]       aw,
    input  logic             long_mode,
    output logic [IDX_W-1:0] nxt
);
    logic [IDX_W-1:0] delta;
    logic [IDX_W-1:0] moved;

    always_comb begin
        delta = IDX_W'(1) << size;
        moved = df ? (idx - delta) : (idx + delta);
        unique case (awidth_e'(aw))
            AW_16:   nxt = {idx[IDX_W-1:16], moved[15:0]};
            AW_32:   nxt = long_mode ? {{(IDX_W-32){1'b0}}, moved[31:0]}
                                     : {idx[IDX_W-1:32], moved[31:0]};
            default: nxt = moved;
        endcase
    end
endmodule

// File: rtl/strstore_unit.sv
module strstore_unit
    import strstore_pkg::*;
#(
    parameter int IDX_W = 64,
    parameter int BUS_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         op_size,
    input  logic [1:0]         addr_size,
    input  logic               dir_flag,
    input  logic [1:0]         cpu_mode,
    input  logic [BUS_W-1:0]   acc,
    input  logic [IDX_W-1:0]   idx_in,
    input  logic [IDX_W-1:0]   es_base,
    output logic               busy,
    output logic               invalid,
    output logic               done,
    output logic [IDX_W-1:0]   idx_out,
    output logic               wr_valid,
    input  logic               wr_ready,
    output logic [IDX_W-1:0]   wr_addr,
    output logic [BUS_W/8-1:0] wr_be,
    output logic [BUS_W-1:0]   wr_data
);
    localparam int NB = BUS_W / 8;

    st_e              state, st_nx;
    req_ctl_t         ctl_q;
    logic [BUS_W-1:0] acc_q;
    logic [IDX_W-1:0] idx_q, base_q, idx_res;
    logic             legal_in, long_in, last_beat;

    logic [IDX_W-1:0] lin, lo_addr, hi_addr, step_nx;
    logic [BUS_W-1:0] lo_data, hi_data;
    logic [NB-1:0]    lo_be, hi_be;
    logic             split;

    strstore_addr #(.IDX_W(IDX_W)) u_addr (
        .idx(idx_q), .seg_base(base_q), .aw(ctl_q.aw),
        .long_mode(ctl_q.long_mode), .lin(lin)
    );

    strstore_lanes #(.IDX_W(IDX_W), .BUS_W(BUS_W)) u_lanes (
        .acc(acc_q), .size(ctl_q.size), .lin(lin),
        .lo_addr(lo_addr), .hi_addr(hi_addr),
        .lo_data(lo_data), .hi_data(hi_data),
        .lo_be(lo_be), .hi_be(hi_be), .split(split)
    );

    strstore_step #(.IDX_W(IDX_W)) u_step (
        .idx(idx_q), .size(ctl_q.size), .df(ctl_q.df), .aw(ctl_q.aw),
        .long_mode(ctl_q.long_mode), .nxt(step_nx)
    );

    // Encoding legality, judged on the inputs presented with start.
    always_comb begin
        long_in = (cpu_mode == MODE_LONG);
        if (long_in)
            legal_in = (awidth_e'(addr_size) == AW_32) || (awidth_e'(addr_size) == AW_64);
        else
            legal_in = (opsize_e'(op_size) != OPS_QWORD) &&
                       ((awidth_e'(addr_size) == AW_16) || (awidth_e'(addr_size) == AW_32));
    end

    // Next-state logic.
    always_comb begin
        st_nx = state;
        unique case (state)
            ST_IDLE:    if (start) st_nx = legal_in ? ST_BEAT_LO : ST_REJECT;
            ST_REJECT:  st_nx = ST_IDLE;
            ST_BEAT_LO: if (wr_ready) st_nx = split ? ST_BEAT_HI : ST_FINISH;
            ST_BEAT_HI: if (wr_ready) st_nx = ST_FINISH;
            ST_FINISH:  st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    assign last_beat = wr_ready &&
                       (((state == ST_BEAT_LO) && !split) || (state == ST_BEAT_HI));

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_nx;
    end

    // Operand capture and index result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            acc_q   <= '0;
            idx_q   <= '0;
            base_q  <= '0;
            idx_res <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                ctl_q.size      <= op_size;
                ctl_q.aw        <= addr_size;
                ctl_q.df        <= dir_flag;
                ctl_q.long_mode <= long_in;
                acc_q           <= acc;
                idx_q           <= idx_in;
                base_q          <= es_base;
            end
            if (last_beat) idx_res <= step_nx;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        busy     = (state != ST_IDLE);
        invalid  = (state == ST_REJECT);
        done     = (state == ST_FINISH);
        wr_valid = (state == ST_BEAT_LO) || (state == ST_BEAT_HI);
        idx_out  = idx_res;
        if (state == ST_BEAT_HI) begin
            wr_addr = hi_addr;
            wr_be   = hi_be;
            wr_data = hi_data;
        end else if (state == ST_BEAT_LO) begin
            wr_addr = lo_addr;
            wr_be   = lo_be;
            wr_data = lo_data;
        end else begin
            wr_addr = '0;
            wr_be   = '0;
            wr_data = '0;
        end
    end
endmodule

// File: rtl/strstore_unit_chk.sv
module strstore_unit_chk #(
    parameter int IDX_W = 64,
    parameter int BUS_W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [1:0]         op_size,
    input logic [1:0]         cpu_mode,
    input logic               busy,
    input logic               invalid,
    input logic               done,
    input logic [IDX_W-1:0]   idx_out,
    input logic               wr_valid,
    input logic               wr_ready,
    input logic [IDX_W-1:0]   wr_addr,
    input logic [BUS_W/8-1:0] wr_be,
    input logic [BUS_W-1:0]   wr_data
);
    // R6: quadword outside 64-bit mode is rejected in the next cycle
    a_r6_qword_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op_size == 2'd3 && cpu_mode != 2'd2) |=> (invalid && !wr_valid));

    // R6: a rejection ends the operation at once
    a_r6_reject_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |=> !busy);

    // R10: write request is held steady while stalled
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=>
            (wr_valid && $stable(wr_addr) && $stable(wr_be) && $stable(wr_data)));

    // R10: index output moves only alongside done
    a_r10_idx_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(idx_out) |-> done);

    // R7: every beat enables at least one lane
    a_r7_be_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_be != '0));

    // R12: done lasts one cycle and releases busy
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R11: a start while busy does not end the operation
    a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !done && !invalid) |=> busy);
endmodule

bind strstore_unit strstore_unit_chk #(.IDX_W(IDX_W), .BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op_size(op_size),
    .cpu_mode(cpu_mode), .busy(busy), .invalid(invalid), .done(done),
    .idx_out(idx_out), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data)
);

// File: tb/strstore_unit_test.sv
`timescale 1ns/1ps
module strstore_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_size = '0, addr_size = '0, cpu_mode = '0;
    logic        dir_flag = 1'b0;
    logic [63:0] acc = '0, idx_in = '0, es_base = '0;
    logic        busy, invalid, done, wr_valid;
    logic        wr_ready = 1'b0;
    logic [63:0] idx_out, wr_addr, wr_data;
    logic [7:0]  wr_be;

    int checks = 0;
    int failures = 0;
    logic [63:0] prev_idx = '0;

    always #2.5 clk = ~clk;

    strstore_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_size(op_size),
        .addr_size(addr_size), .dir_flag(dir_flag), .cpu_mode(cpu_mode),
        .acc(acc), .idx_in(idx_in), .es_base(es_base), .busy(busy),
        .invalid(invalid), .done(done), .idx_out(idx_out),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_be(wr_be), .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit f_legal(input logic [1:0] sz, input logic [1:0] aw, input logic [1:0] md);
        if (md == 2'd2) return (aw == 2'd1) || (aw == 2'd2);
        return (sz != 2'd3) && (aw == 2'd0 || aw == 2'd1);
    endfunction

    function automatic logic [63:0] f_lin(input logic [63:0] ix, input logic [63:0] bs,
                                          input logic [1:0] aw, input logic [1:0] md);
        logic [63:0] o;
        o = (aw == 2'd0) ? {48'd0, ix[15:0]} : (aw == 2'd1) ? {32'd0, ix[31:0]} : ix;
        return (md == 2'd2) ? o : bs + o;
    endfunction

    function automatic logic [63:0] f_next(input logic [63:0] ix, input logic [1:0] sz,
                                           input logic df, input logic [1:0] aw,
                                           input logic [1:0] md);
        logic [63:0] n;
        longint unsigned d;
        d = 64'd1 << sz;
        n = df ? ix - d : ix + d;
        if (aw == 2'd0) return {ix[63:16], n[15:0]};
        if (aw == 2'd1) return (md == 2'd2) ? {32'd0, n[31:0]} : {ix[63:32], n[31:0]};
        return n;
    endfunction

    task automatic run_op(input logic [1:0] sz, input logic [1:0] aw, input logic df,
                          input logic [1:0] md, input logic [63:0] a, input logic [63:0] ix,
                          input logic [63:0] bs, input bit inject);
        logic [63:0] lin, exp_addr, exp_data, b_addr[2], b_data[2];
        logic [7:0]  exp_be, b_be[2];
        int nb, lo, nbytes, cyc;
        bit saw_done, saw_inv;
        nb = 0; saw_done = 0; saw_inv = 0;
        @(negedge clk);
        op_size = sz; addr_size = aw; dir_flag = df; cpu_mode = md;
        acc = a; idx_in = ix; es_base = bs; start = 1'b1; wr_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        // R12: scramble inputs after capture
        acc = {$urandom, $urandom}; idx_in = {$urandom, $urandom};
        es_base = {$urandom, $urandom}; dir_flag = ~df; op_size = ~sz;
        for (cyc = 0; cyc < 60; cyc++) begin
            wr_ready = ($urandom % 10) < 6;
            start = inject && (cyc < 2);
            if (cyc == 0) chk(busy, "R11", "busy after start", busy, 1);
            if (wr_valid && wr_ready && nb < 2) begin
                b_addr[nb] = wr_addr; b_be[nb] = wr_be; b_data[nb] = wr_data; nb++;
            end
            if (invalid) begin saw_inv = 1; break; end
            if (done) begin saw_done = 1; break; end
            @(negedge clk);
        end
        start = 1'b0; wr_ready = 1'b0;
        if (!f_legal(sz, aw, md)) begin
            chk(saw_inv && cyc == 0, "R6", "invalid pulse next cycle", 64'(saw_inv), 1);
            chk(nb == 0, "R6", "no write on invalid", 64'(nb), 0);
            chk(idx_out == prev_idx, "R6", "idx kept on invalid", idx_out, prev_idx);
        end else begin
            lin = f_lin(ix, bs, aw, md);
            lo = int'(lin[2:0]); nbytes = 1 << sz;
            chk(saw_done, "R12", "done reached", 64'(saw_done), 1);
            chk(nb == ((lo + nbytes > 8) ? 2 : 1), "R8", "beat count", 64'(nb),
                64'((lo + nbytes > 8) ? 2 : 1));
            for (int bt = 0; bt < nb; bt++) begin
                exp_addr = {lin[63:3], 3'b000} + 64'(8 * bt);
                exp_be = '0; exp_data = '0;
                for (int k = 0; k < 8; k++) begin
                    int p;
                    p = 8 * bt + k - lo;
                    if (p >= 0 && p < nbytes) begin
                        exp_be[k] = 1'b1;
                        exp_data[8*k +: 8] = a[8*p +: 8];
                    end
                end
                chk(b_addr[bt] == exp_addr, "R2 R3 R8", "beat address", b_addr[bt], exp_addr);
                chk(b_be[bt] == exp_be, "R7", "byte enables", 64'(b_be[bt]), 64'(exp_be));
                chk(b_data[bt] == exp_data, "R1", "beat data", b_data[bt], exp_data);
            end
            chk(idx_out == f_next(ix, sz, df, aw, md), "R4 R5 R9", "index result",
                idx_out, f_next(ix, sz, df, aw, md));
            prev_idx = f_next(ix, sz, df, aw, md);
            @(negedge clk);
            chk(!busy && !done, "R12", "done one cycle", 64'(busy), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !wr_valid && !done && !invalid, "R11", "idle after reset",
            {busy, wr_valid, done, invalid}, 0);
        chk(idx_out == 0, "R10", "index zero after reset", idx_out, 0);

        // Directed corners
        run_op(2'd0, 2'd1, 0, 2'd0, 64'h11, 64'hFFFF_0000_0000_1007, 64'h1000, 0); // R1 byte lane 7, no split
        run_op(2'd1, 2'd0, 0, 2'd1, 64'hBEEF, 64'h1234_0000_0000_0007, 64'h20, 0); // R8 word split
        run_op(2'd3, 2'd2, 0, 2'd2, 64'h0102_0304_0506_0708, 64'h8000_0000_0000_0010, 64'hFFFF, 0);
        run_op(2'd3, 2'd2, 1, 2'd2, 64'hA1A2_A3A4_A5A6_A7A8, 64'h0000_0000_0000_0003, 0, 0); // R9 64 wrap
        run_op(2'd1, 2'd0, 1, 2'd0, 64'h5566, 64'hABCD_0000_1234_0000, 64'h0003_0000, 0); // R9 16-bit wrap
        run_op(2'd2, 2'd1, 0, 2'd2, 64'hCAFE_F00D, 64'hDEAD_BEEF_FFFF_FFFC, 64'h5000, 0); // R9 zero-extend
        run_op(2'd2, 2'd1, 0, 2'd0, 64'h1357_9BDF, 64'hDEAD_BEEF_FFFF_FFFE, 64'h0100_0000, 0); // R9 keep upper
        run_op(2'd3, 2'd1, 0, 2'd0, 64'h1, 64'h40, 0, 0);  // R6 quad in legacy
        run_op(2'd0, 2'd2, 0, 2'd1, 64'h1, 64'h40, 0, 0);  // R6 64-bit addr in compat
        run_op(2'd0, 2'd0, 0, 2'd2, 64'h1, 64'h40, 0, 0);  // R6 16-bit addr in 64-bit mode
        run_op(2'd0, 2'd3, 0, 2'd2, 64'h1, 64'h40, 0, 0);  // R6 reserved address size
        run_op(2'd2, 2'd1, 1, 2'd1, 64'h7777_8888, 64'h0000_0000_0000_0006, 64'h10, 1); // R11 start while busy

        for (int n = 0; n < 300; n++) begin
            logic [1:0] md, aw, sz;
            md = 2'($urandom % 3);
            sz = 2'($urandom % 4);
            aw = (md == 2'd2) ? 2'(1 + $urandom % 2) : 2'($urandom % 2);
            if ($urandom % 8 == 0) aw = 2'($urandom % 4);
            run_op(sz, aw, 1'($urandom), md, {$urandom, $urandom},
                   {$urandom, $urandom}, {$urandom, $urandom}, ($urandom % 6) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule